// File: doc/BRIEF.md
# Qualified Chip Select Decoder

This block turns each bus cycle into at most one active-low chip select strobe. It holds eight programmable channels. Each channel has a base register and a mask register. A channel claims a cycle when the upper twenty address bits equal its base address, ignoring any bits its mask excludes. A channel can also be limited to supervisor accesses, and it can require an exact transfer type and modifier. Several channels may match the same cycle. In that case the lowest-numbered one wins.

Along with the strobe, the block reports the bus width and the external interface mode of the winning channel, so that the downstream bus sequencer can pick the right access timing. A user-mode access that lands in a supervisor-only region asserts no strobe and raises an access error instead.

Software programs the channels through a plain register write/read port. Channel 0 is the boot channel. Its width field is loaded from two strap pins while reset is held, so the first instruction fetch uses the correct data width.

Top module: `csel_decoder`

## Requirements
- R1: While reset is held and afterwards until written, the base register of channel n (n = 1..6) reads (n << 12) | 0x300. Channel 7 reads 0x0000_7700. Every mask register reads 0.
- R2: Channel 0's base register resets to 0x0000_0001 with bits 9:8 equal to the strap_width value sampled during reset.
- R3: The base register of channel n sits at offset 0x40 + 8n and its mask register at 0x44 + 8n. Mask bits 11:0 read as 0. A read of any other offset returns 0. A write to any other offset, or with reg_wr low, changes no register.
- R4: Base register layout, bit positions: base address 31:12, mode 11:10, width 9:8, supervisor-only 7, transfer type 6:5, modifier 4:2, compare-type enable 1, channel enable 0. An enabled channel hits when bus_addr[31:12] equals its base address in every bit whose mask bit (mask register bits 31:12) is 0. A disabled channel never hits.
- R5: When several channels hit, only the lowest-numbered one is considered. At most one cs_n bit is ever low.
- R6: While bus_valid is low, cs_n is all ones, acc_err is 0, and sel_width and sel_mode are 0.
- R7: A winning supervisor-only channel (bit 7 set) asserts its chip select only when bus_super is 1. A user access instead sets acc_err and leaves cs_n all ones.
- R8: When the compare-type enable (bit 1) is set, a channel hits only if bus_tt equals bits 6:5 and bus_tm equals bits 4:2.
- R9: sel_width reports bits 9:8 of the winning channel (00 = 32-bit, 01 = 8-bit, 10 = 16-bit, 11 = 32-bit line). It reports 00 when no channel wins.
- R10: sel_mode reports bits 11:10 of the winning channel, with two substitutions. The reserved code 10 reports as 00. Code 01 (SDRAM) reports as 01 only on channel 7 and as 00 on other channels. It reports 00 when no channel wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_width | input | 2 | Boot width for channel 0, sampled while reset is held |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| bus_valid | input | 1 | Bus cycle in progress |
| bus_addr | input | 32 | Bus cycle address |
| bus_tt | input | 2 | Bus cycle transfer type |
| bus_tm | input | 3 | Bus cycle transfer modifier |
| bus_super | input | 1 | 1 = supervisor access, 0 = user access |
| cs_n | output | 8 | Active-low chip selects, one per channel |
| acc_err | output | 1 | Access error: user access to a supervisor-only region |
| sel_width | output | 2 | Bus width of the winning channel |
| sel_mode | output | 2 | Interface mode of the winning channel |

## Verification
The assertions check several output properties on every cycle:
- the strobes are at most one-hot;
- an idle bus drives nothing;
- an error never coincides with a strobe, and a supervisor access never raises an error;
- the reserved mode code never appears on sel_mode, and the SDRAM code appears only with channel 7.

Other behaviour depends on register contents and can only be shown by the bench's scenarios:
- mask handling and the base/mask offsets;
- the strap-loaded boot width;
- which of several overlapping channels wins;
- exact transfer type and modifier qualification.

// File: rtl/csel_pkg.sv
package csel_pkg;
    localparam int ADDR_W   = 32;
    localparam int BA_LSB   = 12;
    localparam int BA_W     = ADDR_W - BA_LSB;
    localparam int SDRAM_CH = 7;
    localparam logic [7:0] REG_BASE = 8'h40;
    localparam logic [7:0] REG_STEP = 8'h08;
    localparam logic [7:0] MASK_OFS = 8'h04;

    typedef struct packed {
        logic [BA_W-1:0] ba;
        logic [1:0]      mode;
        logic [1:0]      width;
        logic            sup;
        logic [1:0]      tt;
        logic [2:0]      tm;
        logic            ctm;
        logic            en;
    } base_t;

    function automatic logic [7:0] base_off(input int ch);
        return 8'(int'(REG_BASE) + int'(REG_STEP) * ch);
    endfunction

    function automatic base_t rst_base(input int ch, input logic [1:0] strap);
        base_t r;
        r = '0;
        r.ba = BA_W'(ch);
        if (ch == 0) begin
            r.width = strap;
            r.en    = 1'b1;
        end else if (ch == SDRAM_CH) begin
            r.mode  = 2'b01;
            r.width = 2'b11;
        end else begin
            r.width = 2'b11;
        end
        return r;
    endfunction
endpackage

// File: rtl/csel_regfile.sv
module csel_regfile
    import csel_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   strap_width,
    input  logic                         reg_wr,
    input  logic [7:0]                   reg_addr,
    input  logic [31:0]                  reg_wdata,
    output logic [31:0]                  reg_rdata,
    output base_t [NUM_CH-1:0]           cfg_base,
    output logic [NUM_CH-1:0][BA_W-1:0]  cfg_mask
);
    typedef struct packed {
        base_t [NUM_CH-1:0]          base;
        logic [NUM_CH-1:0][BA_W-1:0] mask;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) begin
                s_d.base[i] = rst_base(i, strap_width);
                s_d.mask[i] = '0;
            end
        end else if (reg_wr) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (reg_addr == base_off(i))
                    s_d.base[i] = base_t'(reg_wdata);
                if (reg_addr == (base_off(i) | MASK_OFS))
                    s_d.mask[i] = reg_wdata[ADDR_W-1:BA_LSB];
            end
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (reg_addr == base_off(i))
                reg_rdata = s_q.base[i];
            if (reg_addr == (base_off(i) | MASK_OFS))
                reg_rdata = {s_q.mask[i], {BA_LSB{1'b0}}};
        end
    end

    assign cfg_base = s_q.base;
    assign cfg_mask = s_q.mask;
endmodule

// File: rtl/csel_match.sv
module csel_match
    import csel_pkg::*;
(
    input  base_t           cfg,
    input  logic [BA_W-1:0] mask,
    input  logic [BA_W-1:0] addr_hi,
    input  logic [1:0]      tt,
    input  logic [2:0]      tm,
    output logic            hit
);
    logic addr_ok, type_ok;

    assign addr_ok = (((addr_hi ^ cfg.ba) & ~mask) == '0);
    assign type_ok = !cfg.ctm || ((tt == cfg.tt) && (tm == cfg.tm));
    assign hit     = cfg.en && addr_ok && type_ok;
endmodule

// File: rtl/csel_arbiter.sv
module csel_arbiter
    import csel_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  base_t [NUM_CH-1:0] cfg_base,
    input  logic [NUM_CH-1:0]  hit,
    input  logic               bus_valid,
    input  logic               bus_super,
    output logic [NUM_CH-1:0]  cs_n,
    output logic               acc_err,
    output logic [1:0]         sel_width,
    output logic [1:0]         sel_mode
);
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [IDX_W-1:0] win;
    logic             any;
    base_t            wcfg;

    always_comb begin
        win = '0;
        any = 1'b0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (hit[i]) begin
                win = IDX_W'(i);
                any = 1'b1;
            end
        end
    end

    always_comb begin
        wcfg      = cfg_base[win];
        cs_n      = '1;
        acc_err   = 1'b0;
        sel_width = 2'b00;
        sel_mode  = 2'b00;
        if (bus_valid && any) begin
            if (wcfg.sup && !bus_super)
                acc_err = 1'b1;
            else
                cs_n[win] = 1'b0;
            sel_width = wcfg.width;
            case (wcfg.mode)
                2'b11:   sel_mode = 2'b11;
                2'b01:   sel_mode = (int'(win) == SDRAM_CH) ? 2'b01 : 2'b00;
                default: sel_mode = 2'b00;
            endcase
        end
    end
endmodule

// File: rtl/csel_decoder.sv
module csel_decoder
    import csel_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        strap_width,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              bus_valid,
    input  logic [31:0]       bus_addr,
    input  logic [1:0]        bus_tt,
    input  logic [2:0]        bus_tm,
    input  logic              bus_super,
    output logic [NUM_CH-1:0] cs_n,
    output logic              acc_err,
    output logic [1:0]        sel_width,
    output logic [1:0]        sel_mode
);
    base_t [NUM_CH-1:0]          cfg_base;
    logic [NUM_CH-1:0][BA_W-1:0] cfg_mask;
    logic [NUM_CH-1:0]           hit;
    logic                        unused_addr_lo;

    assign unused_addr_lo = ^bus_addr[BA_LSB-1:0];

    csel_regfile #(.NUM_CH(NUM_CH)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_width (strap_width),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .cfg_base    (cfg_base),
        .cfg_mask    (cfg_mask)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        csel_match u_match (
            .cfg     (cfg_base[g]),
            .mask    (cfg_mask[g]),
            .addr_hi (bus_addr[ADDR_W-1:BA_LSB]),
            .tt      (bus_tt),
            .tm      (bus_tm),
            .hit     (hit[g])
        );
    end

    csel_arbiter #(.NUM_CH(NUM_CH)) u_arb (
        .cfg_base  (cfg_base),
        .hit       (hit),
        .bus_valid (bus_valid),
        .bus_super (bus_super),
        .cs_n      (cs_n),
        .acc_err   (acc_err),
        .sel_width (sel_width),
        .sel_mode  (sel_mode)
    );
endmodule

// File: rtl/csel_checker.sv
module csel_checker #(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_super,
    input logic [NUM_CH-1:0] cs_n,
    input logic              acc_err,
    input logic [1:0]        sel_width,
    input logic [1:0]        sel_mode
);
    a_r5_single_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> (&cs_n && !acc_err && sel_width == 2'b00 && sel_mode == 2'b00));

    a_r7_error_blocks_select: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> &cs_n);

    a_r7_super_never_errs: assert property (@(posedge clk) disable iff (!rst_n)
        bus_super |-> !acc_err);

    a_r10_no_reserved_mode: assert property (@(posedge clk) disable iff (!rst_n)
        sel_mode != 2'b10);

    a_r10_sdram_only_ch7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_mode == 2'b01) |-> (!cs_n[NUM_CH-1] || acc_err));

    a_r9_no_winner_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n && !acc_err) |-> (sel_width == 2'b00 && sel_mode == 2'b00));
endmodule

bind csel_decoder csel_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_super (bus_super),
    .cs_n      (cs_n),
    .acc_err   (acc_err),
    .sel_width (sel_width),
    .sel_mode  (sel_mode)
);

// File: tb/sim_csel_decoder.sv
`timescale 1ns/1ps
module sim_csel_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  strap_width = 2'b10;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [1:0]  bus_tt = '0;
    logic [2:0]  bus_tm = '0;
    logic        bus_super = 1'b1;
    logic [7:0]  cs_n;
    logic        acc_err;
    logic [1:0]  sel_width;
    logic [1:0]  sel_mode;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    csel_decoder u0 (
        .clk(clk), .rst_n(rst_n), .strap_width(strap_width),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_tt(bus_tt), .bus_tm(bus_tm),
        .bus_super(bus_super), .cs_n(cs_n), .acc_err(acc_err),
        .sel_width(sel_width), .sel_mode(sel_mode)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1 chk(req, reg_rdata, exp);
    endtask

    task automatic bus(input logic v, input logic [31:0] a, input logic s,
                       input logic [1:0] tt, input logic [2:0] tm);
        @(negedge clk);
        bus_valid = v; bus_addr = a; bus_super = s; bus_tt = tt; bus_tm = tm;
        #1;
    endtask

    task automatic outs(input string req, input logic [7:0] ecs, input logic eerr,
                        input logic [1:0] ew, input logic [1:0] em);
        chk({req, " cs_n"}, {24'h0, cs_n}, {24'h0, ecs});
        chk({req, " acc_err"}, {31'h0, acc_err}, {31'h0, eerr});
        chk({req, " sel_width"}, {30'h0, sel_width}, {30'h0, ew});
        chk({req, " sel_mode"}, {30'h0, sel_mode}, {30'h0, em});
    endtask

    task automatic t_reset();
        rd("R2 ch0 reset with strap", 8'h40, 32'h0000_0201);
        for (int n = 1; n <= 6; n++)
            rd("R1 ch1-6 reset", 8'(8'h40 + 8 * n), (32'(n) << 12) | 32'h300);
        rd("R1 ch7 reset", 8'h78, 32'h0000_7700);
        rd("R1 mask0 reset", 8'h44, 32'h0);
        rd("R1 mask7 reset", 8'h7C, 32'h0);
        bus(1'b1, 32'h0000_0100, 1'b1, 2'd0, 3'd0);
        outs("R2 boot ch0 width from strap", 8'hFE, 1'b0, 2'b10, 2'b00);
    endtask

    task automatic t_regs();
        wr(8'h48, 32'h0010_0101);
        rd("R3 base write readback", 8'h48, 32'h0010_0101);
        wr(8'h4C, 32'hFFFF_FFFF);
        rd("R3 mask low bits read 0", 8'h4C, 32'hFFFF_F000);
        wr(8'h4C, 32'h0);
        wr(8'h80, 32'hDEAD_BEEF);
        rd("R3 unmapped read 0", 8'h80, 32'h0);
        rd("R3 unmapped write no effect", 8'h40, 32'h0000_0201);
        @(negedge clk);
        reg_addr = 8'h48; reg_wdata = 32'h1234_5678; reg_wr = 1'b0;
        @(negedge clk);
        rd("R3 no write without strobe", 8'h48, 32'h0010_0101);
    endtask

    task automatic t_mask();
        bus(1'b1, 32'h0010_0ABC, 1'b0, 2'd0, 3'd0);
        outs("R4 exact base hit ch1", 8'hFD, 1'b0, 2'b01, 2'b00);
        bus(1'b1, 32'h0030_0000, 1'b0, 2'd0, 3'd0);
        outs("R4 miss without mask", 8'hFF, 1'b0, 2'b00, 2'b00);
        wr(8'h4C, 32'h0020_0000);
        bus(1'b1, 32'h0030_0000, 1'b0, 2'd0, 3'd0);
        outs("R4 masked bit ignored", 8'hFD, 1'b0, 2'b01, 2'b00);
        wr(8'h48, 32'h0010_0100);
        bus(1'b1, 32'h0010_0000, 1'b0, 2'd0, 3'd0);
        outs("R4 disabled channel no hit", 8'hFF, 1'b0, 2'b00, 2'b00);
        wr(8'h4C, 32'h0);
    endtask

    task automatic t_priority();
        wr(8'h50, 32'h0000_0101);
        bus(1'b1, 32'h0000_0100, 1'b0, 2'd0, 3'd0);
        outs("R5 lowest channel wins", 8'hFE, 1'b0, 2'b10, 2'b00);
        wr(8'h40, 32'h0000_0200);
        bus(1'b1, 32'h0000_0100, 1'b0, 2'd0, 3'd0);
        outs("R5 next channel after disable", 8'hFB, 1'b0, 2'b01, 2'b00);
        wr(8'h40, 32'h0000_0201);
        wr(8'h50, 32'h0);
    endtask

    task automatic t_idle();
        bus(1'b0, 32'h0000_0100, 1'b0, 2'd0, 3'd0);
        outs("R6 invalid cycle quiet", 8'hFF, 1'b0, 2'b00, 2'b00);
    endtask

    task automatic t_super();
        wr(8'h58, 32'h0050_0081);
        bus(1'b1, 32'h0050_0010, 1'b0, 2'd0, 3'd0);
        outs("R7 user hits super region", 8'hFF, 1'b1, 2'b00, 2'b00);
        bus(1'b1, 32'h0050_0010, 1'b1, 2'd0, 3'd0);
        outs("R7 super access selects", 8'hF7, 1'b0, 2'b00, 2'b00);
        bus(1'b1, 32'h0090_0010, 1'b0, 2'd0, 3'd0);
        outs("R7 user miss no error", 8'hFF, 1'b0, 2'b00, 2'b00);
    endtask

    task automatic t_ctm();
        wr(8'h60, 32'h0060_0057);
        bus(1'b1, 32'h0060_0000, 1'b0, 2'd2, 3'd5);
        outs("R8 type and modifier equal", 8'hEF, 1'b0, 2'b00, 2'b00);
        bus(1'b1, 32'h0060_0000, 1'b0, 2'd1, 3'd5);
        outs("R8 type differs", 8'hFF, 1'b0, 2'b00, 2'b00);
        bus(1'b1, 32'h0060_0000, 1'b0, 2'd2, 3'd4);
        outs("R8 modifier differs", 8'hFF, 1'b0, 2'b00, 2'b00);
    endtask

    task automatic t_mode();
        wr(8'h68, 32'h0070_0A01);
        bus(1'b1, 32'h0070_0000, 1'b0, 2'd0, 3'd0);
        outs("R10 reserved mode as 00 / R9 width", 8'hDF, 1'b0, 2'b10, 2'b00);
        wr(8'h68, 32'h0070_0E01);
        bus(1'b1, 32'h0070_0000, 1'b0, 2'd0, 3'd0);
        outs("R10 mode 11", 8'hDF, 1'b0, 2'b10, 2'b11);
        wr(8'h68, 32'h0070_0401);
        bus(1'b1, 32'h0070_0000, 1'b0, 2'd0, 3'd0);
        outs("R10 sdram code off ch7", 8'hDF, 1'b0, 2'b00, 2'b00);
        wr(8'h78, 32'h0000_7701);
        bus(1'b1, 32'h0000_7000, 1'b0, 2'd0, 3'd0);
        outs("R10 sdram on ch7 / R9 width 11", 8'h7F, 1'b0, 2'b11, 2'b01);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        strap_width = 2'b00;
        bus(1'b0, 32'h0, 1'b1, 2'd0, 3'd0);
        outs("R6 reset idle outputs", 8'hFF, 1'b0, 2'b00, 2'b00);
        t_reset();
        t_regs();
        t_mask();
        t_priority();
        t_idle();
        t_super();
        t_ctm();
        t_mode();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule